// File: doc/BRIEF.md
# Parallel-Access Shift Register with J/K Entry Stage

This block is a register of `WIDTH` stages (four by default) clocked on the rising edge. A single active-low select chooses, at each edge, between capturing a full parallel word and moving the contents one place toward the last stage. While moving, the entry stage (stage 0) does not take a plain serial bit. Instead, a J input and an active-low K input together decide whether stage 0 is set, cleared, inverted or left alone. Driving both inputs from one wire turns stage 0 into an ordinary D-type serial input.

All stage values are visible as outputs. A separate output always carries the inverse of the last stage. An active-low asynchronous clear forces every stage to zero as soon as it goes low. It overrides the clock and every other input.

A left-moving register is built outside the block. Each output n is wired to parallel input n-1, a serial bit is fed into the top parallel input, and the select is held in load.

Top module: `jk_shift_reg`

## Requirements
- R1: With `loadN` low at a rising edge, every stage n takes `parIn[n]`.
- R2: With `loadN` high at a rising edge, every stage n >= 1 takes the value stage n-1 held before the edge.
- R3: During a move, `jIn`=1 with `kBarIn`=1 sets stage 0 to 1.
- R4: During a move, `jIn`=0 with `kBarIn`=0 clears stage 0 to 0.
- R5: During a move, `jIn`=1 with `kBarIn`=0 gives stage 0 the inverse of its previous value.
- R6: During a move, `jIn`=0 with `kBarIn`=1 leaves stage 0 at its previous value.
- R7: Driving `rstAsyncN` low clears all stages at once, without waiting for a clock edge, and `lastInv` then reads 1.
- R8: `lastInv` always equals the inverse of stage `WIDTH-1`.
- R9: With `jIn` and `kBarIn` tied to one serial bit, each move enters that bit into stage 0.
- R10: While `rstAsyncN` is held low, rising edges with a load or a move pending leave all stages at 0.
- R11: Wiring `stageOut[n]` to `parIn[n-1]`, feeding a serial bit into `parIn[WIDTH-1]` and holding `loadN` low moves the contents one place toward stage 0 on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstAsyncN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | 0 = parallel load, 1 = move toward the last stage |
| jIn | input | 1 | J input of stage 0 |
| kBarIn | input | 1 | Active-low K input of stage 0 |
| parIn | input | WIDTH | Parallel data, bit n feeds stage n |
| stageOut | output | WIDTH | Present value of every stage |
| lastInv | output | 1 | Inverse of the last stage |

## Verification
The main sweep covers every 4-bit start state against all eight combinations of the select, J and K inputs. The parallel word is chosen to differ from the start state, so a load cannot be mistaken for a hold or a move, and each J/K combination shows up as a different stage-0 result. Serial streams on the tied J/K pair and on the externally wired left-move loop check the order in which bits travel through the stages. A clear applied between edges, and then held across edges that carry a pending load, separates asynchronous clearing from synchronous clearing and shows that the clear has priority.

// File: rtl/jksr_pkg.sv
package jksr_pkg;

  typedef enum logic [1:0] {
    FO_HOLD   = 2'd0,
    FO_CLEAR  = 2'd1,
    FO_SET    = 2'd2,
    FO_TOGGLE = 2'd3
  } firstOp_t;

  typedef struct packed {
    logic     doLoad;
    logic     doShift;
    firstOp_t firstOp;
  } ctrlStrobe_t;

endpackage

// File: rtl/jksr_ctrl.sv
module jksr_ctrl
  import jksr_pkg::*;
(
  input  logic        loadN,
  input  logic        jIn,
  input  logic        kBarIn,
  output ctrlStrobe_t stb
);

  always_comb begin
    stb.doLoad  = ~loadN;
    stb.doShift = loadN;
    unique case ({jIn, kBarIn})
      2'b00:   stb.firstOp = FO_CLEAR;
      2'b01:   stb.firstOp = FO_HOLD;
      2'b10:   stb.firstOp = FO_TOGGLE;
      default: stb.firstOp = FO_SET;
    endcase
  end

endmodule

// File: rtl/jksr_datapath.sv
module jksr_datapath
  import jksr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstAsyncN,
  input  ctrlStrobe_t      stb,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  logic             firstNext;
  logic [WIDTH-1:0] moveNext;

  always_comb begin
    unique case (stb.firstOp)
      FO_CLEAR:  firstNext = 1'b0;
      FO_SET:    firstNext = 1'b1;
      FO_TOGGLE: firstNext = ~stageQ[0];
      default:   firstNext = stageQ[0];
    endcase
  end

  assign moveNext[0] = firstNext;
  for (genvar n = 1; n <= LAST; n++) begin : g_link
    assign moveNext[n] = stageQ[n-1];
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN)       stageQ <= '0;
    else if (stb.doLoad)  stageQ <= parIn;
    else if (stb.doShift) stageQ <= moveNext;
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstAsyncN)
    stb.doLoad |=> stageQ == $past(parIn)); // R1
  AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (stb.doShift && !stb.doLoad) |=> stageQ[LAST:1] == $past(stageQ[LAST-1:0])); // R2
  AST_FIRST_SET: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (stb.doShift && !stb.doLoad && stb.firstOp == FO_SET) |=> stageQ[0]); // R3
  AST_FIRST_CLEAR: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (stb.doShift && !stb.doLoad && stb.firstOp == FO_CLEAR) |=> !stageQ[0]); // R4
  AST_FIRST_TOGGLE: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (stb.doShift && !stb.doLoad && stb.firstOp == FO_TOGGLE) |=> stageQ[0] != $past(stageQ[0])); // R5
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (stb.doShift && !stb.doLoad && stb.firstOp == FO_HOLD) |=> $stable(stageQ[0])); // R6

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
  import jksr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstAsyncN,
  input  logic             loadN,
  input  logic             jIn,
  input  logic             kBarIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageOut,
  output logic             lastInv
);

  if (WIDTH < 2) begin : g_bad_width
    $error("jk_shift_reg needs WIDTH of at least 2");
  end

  ctrlStrobe_t stb;

  jksr_ctrl u_ctrl (
    .loadN  (loadN),
    .jIn    (jIn),
    .kBarIn (kBarIn),
    .stb    (stb)
  );

  jksr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstAsyncN (rstAsyncN),
    .stb       (stb),
    .parIn     (parIn),
    .stageQ    (stageOut)
  );

  assign lastInv = ~stageOut[WIDTH-1];

endmodule

// File: tb/jk_shift_reg_bench.sv
`timescale 1ns/1ps
module jk_shift_reg_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstAsyncN = 1'b0;
  logic         loadN = 1'b0;
  logic         jIn = 1'b0;
  logic         kBarIn = 1'b0;
  logic [W-1:0] parReg = '0;
  logic         wired = 1'b0;
  logic         serBit = 1'b0;
  logic [W-1:0] parIn;
  logic [W-1:0] stageOut;
  logic         lastInv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // External left-move wiring: output n feeds parallel input n-1
  assign parIn = wired ? {serBit, stageOut[W-1:1]} : parReg;

  jk_shift_reg #(.WIDTH(W)) u_jk_shift_reg (
    .clk(clk), .rstAsyncN(rstAsyncN), .loadN(loadN), .jIn(jIn),
    .kBarIn(kBarIn), .parIn(parIn), .stageOut(stageOut), .lastInv(lastInv)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if ({lastInv, stageOut} !== {~exp[W-1], exp}) begin
      fails++;
      $display("FAIL %s actual q=%b inv=%b expected q=%b inv=%b",
               req, stageOut, lastInv, exp, ~exp[W-1]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] model;
    #1;
    check("R7 reset state", '0);
    step();
    rstAsyncN = 1'b1;

    // Every start state against every select/J/K combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 8; c++) begin
        loadN = 1'b0; jIn = 1'b0; kBarIn = 1'b0; parReg = W'(s);
        step();
        loadN = c[2]; jIn = c[1]; kBarIn = c[0];
        parReg = ~W'(s) ^ W'(c);
        step();
        if (!c[2]) begin
          model = ~W'(s) ^ W'(c);
          check("R1 R8 load", model);
        end else begin
          model = {W'(s) << 1} & ~W'(1);
          case (c[1:0])
            2'b11: begin model[0] = 1'b1;   check("R2 R3 set", model); end
            2'b00: begin model[0] = 1'b0;   check("R2 R4 clear", model); end
            2'b10: begin model[0] = ~s[0];  check("R2 R5 toggle", model); end
            default: begin model[0] = s[0]; check("R2 R6 hold", model); end
          endcase
        end
      end
    end

    // Tied J/K as D serial input
    loadN = 1'b0; parReg = 4'b0110;
    step();
    model = 4'b0110;
    loadN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      jIn = (8'b1011_0010 >> i) & 1'b1;
      kBarIn = jIn;
      step();
      model = {model[W-2:0], jIn};
      check("R9 tied serial", model);
    end

    // Asynchronous clear between edges
    loadN = 1'b0; parReg = 4'hF;
    step();
    check("R1 preload", 4'hF);
    rstAsyncN = 1'b0;
    #0.5;
    check("R7 async clear", '0);
    parReg = 4'hA;
    step();
    check("R10 clear holds over load", '0);
    loadN = 1'b1; jIn = 1'b1; kBarIn = 1'b1;
    step();
    check("R10 clear holds over move", '0);
    rstAsyncN = 1'b1;

    // External left-move wiring
    loadN = 1'b0; parReg = 4'b1001;
    step();
    model = 4'b1001;
    wired = 1'b1;
    for (int i = 0; i < 8; i++) begin
      serBit = (8'b0110_1101 >> i) & 1'b1;
      step();
      model = {serBit, model[W-1:1]};
      check("R11 wired left move", model);
    end
    wired = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule